// File: doc/BRIEF.md
# Debug Halt and Single-Step Controller

This block sits between an external debugger and a processor core and decides when the core may run. Through a small register port the debugger can switch debug mode on, stop the core, let it go again, or let exactly one instruction through. It can also mask interrupts while stepping. The controller also watches the core's debug event lines: breakpoint, watchpoint, external request, core reset and hard fault. Any of these can stop the core. The reason for each stop is kept in a sticky flag register until the debugger clears it.

There are three registers. Select 0 is the control/status word. Writes to it take effect only when the upper half carries the unlock key. Reads return the stored control bits together with live and sticky status. Select 1 is the stop-reason register, with write-one-to-clear flags. Select 2 is the event-catch enable register. Reads are combinational, so a read returns data in the cycle `reg_rd` is high. Writes and read side effects take effect at the next rising clock edge.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write to select 0 updates the control bits only when `reg_wdata[31:16]` equals 16'hA05F; any other write to select 0 leaves every control bit unchanged.
- R2: Control bits in select 0 read back as: enable bit 0, stop request bit 1, step bit 2, interrupt mask bit 3, snapshot-stall bit 5; all other bits below 16 read 0.
- R3: Status bits in select 0 read as: bit 16 and bit 17 both high while the core is stopped, bit 18 follows `core_sleep`, bit 19 follows `core_lockup`.
- R4: Bit 25 of select 0 is set by `core_rst` and stays set until a read of select 0; the read returns 1 and the bit is 0 in the following cycle, unless `core_rst` is high again.
- R5: Bit 24 of select 0 is set by `insn_ret` and is cleared by a read of select 0 in the same way as R4.
- R6: Select 1 holds five stop-reason flags: bit 0 request or step, bit 1 breakpoint, bit 2 watchpoint, bit 3 event catch, bit 4 external. The flags are sticky. Writing 1 to a bit clears it, and writing 5'h1F clears all five.
- R7: With debug enabled and the stop request bit set, `core_halt` rises one cycle after the request is visible and sets reason bit 0. After a keyed write clears the stop request bit, `core_halt` falls one cycle after the write's clock edge.
- R8: With enable and step set and the stop request bit clear, `step_go` is high while the core runs. The first `insn_ret` stops the core on the next edge, with reason bit 0 set and the stop request bit set again.
- R9: While the core is running with debug enabled, `bkpt_hit`, `wpt_hit` and `ext_req` each stop the core on the next edge, set reason bit 1, 2 or 4 respectively, and set the stop request bit.
- R10: Select 2 stores the core-reset catch at bit 0, the hard-fault catch at bit 10 and a trace-enable bit at bit 24; other bits read 0. While the core is running with debug enabled, `core_rst` with bit 0 set or `hard_fault` with bit 10 set stops the core and sets reason bit 3.
- R11: While debug enable is 0, `core_halt` is 0 one cycle later, and stop requests and events stop nothing and set no reason flag.
- R12: `irq_mask` is high exactly when the enable bit and the interrupt-mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control/status, 1 stop reason, 2 event catch |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read-clear flags) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| core_halt | output | 1 | Core must stay stopped |
| step_go | output | 1 | Core may retire one instruction |
| irq_mask | output | 1 | Interrupts masked for the core |
| bkpt_hit | input | 1 | Breakpoint matched |
| wpt_hit | input | 1 | Watchpoint matched |
| hard_fault | input | 1 | Hard-fault entry event |
| ext_req | input | 1 | External debug request |
| core_rst | input | 1 | Core is in reset |
| insn_ret | input | 1 | Instruction retired strobe |
| core_sleep | input | 1 | Core sleeping |
| core_lockup | input | 1 | Core locked up |

## Verification
The embedded properties check the following on every cycle: unkeyed writes never move the stored control bits, and the stop-reason flags never drop without a write to select 1. They also check that a breakpoint or a retired step instruction always leads to a stop with the right flag, that the core is released whenever debug is disabled, and that the sticky reset flag holds until a read. The clear-on-read timing, the exact readback layout of all three registers, and the ordering of release, step and re-stop across several register writes are shown only by the bench's scenarios. In those scenarios a behavioural model is compared with every output on every clock.

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
  parameter logic [15:0] KEY = 16'hA05F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        core_halt,
  output logic        step_go,
  output logic        irq_mask,
  input  logic        bkpt_hit,
  input  logic        wpt_hit,
  input  logic        hard_fault,
  input  logic        ext_req,
  input  logic        core_rst,
  input  logic        insn_ret,
  input  logic        core_sleep,
  input  logic        core_lockup
);

  logic       en_q, stop_q, step_q, mask_q, snap_q;
  logic       halted_q;
  logic [4:0] why_q;
  logic       cat_rst_q, cat_hard_q, cat_trc_q;
  logic       rst_seen_q, ret_seen_q;

  logic       wr_ctl, keyed, wr_why, wr_cat, rd_ctl, running, stop_now;
  logic [4:0] cause;

  assign wr_ctl = reg_wr && reg_sel == 2'd0;
  assign keyed  = wr_ctl && reg_wdata[31:16] == KEY;
  assign wr_why = reg_wr && reg_sel == 2'd1;
  assign wr_cat = reg_wr && reg_sel == 2'd2;
  assign rd_ctl = reg_rd && reg_sel == 2'd0;

  assign running  = en_q && !halted_q;
  assign cause[0] = running && (stop_q || (step_q && insn_ret));
  assign cause[1] = running && bkpt_hit;
  assign cause[2] = running && wpt_hit;
  assign cause[3] = running && ((core_rst && cat_rst_q) || (hard_fault && cat_hard_q));
  assign cause[4] = running && ext_req;
  assign stop_now = |cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; stop_q <= 1'b0; step_q <= 1'b0; mask_q <= 1'b0; snap_q <= 1'b0;
    end else if (keyed) begin
      en_q   <= reg_wdata[0];
      stop_q <= reg_wdata[1] || stop_now;
      step_q <= reg_wdata[2];
      mask_q <= reg_wdata[3];
      snap_q <= reg_wdata[5];
    end else if (stop_now) begin
      stop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q   <= 1'b0;
      why_q      <= '0;
      rst_seen_q <= 1'b0;
      ret_seen_q <= 1'b0;
    end else begin
      halted_q   <= en_q && (stop_now || (halted_q && stop_q));
      why_q      <= (why_q & ~(wr_why ? reg_wdata[4:0] : 5'd0)) | cause;
      rst_seen_q <= core_rst || (rst_seen_q && !rd_ctl);
      ret_seen_q <= insn_ret || (ret_seen_q && !rd_ctl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cat_rst_q <= 1'b0; cat_hard_q <= 1'b0; cat_trc_q <= 1'b0;
    end else if (wr_cat) begin
      cat_rst_q  <= reg_wdata[0];
      cat_hard_q <= reg_wdata[10];
      cat_trc_q  <= reg_wdata[24];
    end
  end

  assign core_halt = halted_q;
  assign step_go   = en_q && step_q && !stop_q && !halted_q;
  assign irq_mask  = en_q && mask_q;

  always_comb begin
    unique case (reg_sel)
      2'd0: reg_rdata = {6'b0, rst_seen_q, ret_seen_q, 4'b0, core_lockup, core_sleep,
                         halted_q, halted_q, 10'b0, snap_q, 1'b0, mask_q, step_q, stop_q, en_q};
      2'd1: reg_rdata = {27'b0, why_q};
      2'd2: reg_rdata = {7'b0, cat_trc_q, 13'b0, cat_hard_q, 9'b0, cat_rst_q};
      default: reg_rdata = 32'b0;
    endcase
  end

  p_key_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[31:16] != KEY) |=> ($stable(reg_rdata[0]) || reg_sel != 2'd0 || !$stable(reg_sel)) && $stable(irq_mask));

  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] == 1'b0 && reg_sel == 2'd0) |=> !core_halt);

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && insn_ret) |=> core_halt && why_q[0]);

  p_bkpt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !core_halt && bkpt_hit) |=> core_halt && why_q[1]);

  p_sticky_why_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_why |=> ((why_q & $past(why_q)) == $past(why_q)));

  p_rst_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen_q && !rd_ctl) |=> rst_seen_q);

  p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !(reg_sel == 2'd0 && reg_rdata[0] == 1'b0));

endmodule

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic core_halt, step_go, irq_mask;
  logic bkpt_hit = 0, wpt_hit = 0, hard_fault = 0, ext_req = 0, core_rst = 0, insn_ret = 0;
  logic core_sleep = 0, core_lockup = 0;

  always #5 clk = ~clk;

  dbg_halt_ctrl uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit m_en, m_stop, m_step, m_mask, m_snap, m_halted, m_rs, m_rt, m_cr, m_ch, m_ct;
  bit [4:0] m_why;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    logic [31:0] v = 0;
    if (s == 0) begin
      v[0] = m_en; v[1] = m_stop; v[2] = m_step; v[3] = m_mask; v[5] = m_snap;
      v[16] = m_halted; v[17] = m_halted; v[18] = core_sleep; v[19] = core_lockup;
      v[24] = m_rt; v[25] = m_rs;
    end else if (s == 1) v[4:0] = m_why;
    else if (s == 2) begin v[0] = m_cr; v[10] = m_ch; v[24] = m_ct; end
    return v;
  endfunction

  task automatic cyc();
    bit run, keyed, stopn;
    bit [4:0] cz;
    @(negedge clk);
    check(reg_rdata, exp_rd(reg_sel), reg_sel == 0 ? "R3 status" : reg_sel == 1 ? "R6 reason" : "R10 catch");
    check(core_halt, m_halted, "R7 core_halt");
    check(step_go, m_en && m_step && !m_stop && !m_halted, "R8 step_go");
    check(irq_mask, m_en && m_mask, "R12 irq_mask");
    run = m_en && !m_halted;
    cz = 0;
    if (run) begin
      if (m_stop || (m_step && insn_ret)) cz[0] = 1;
      if (bkpt_hit) cz[1] = 1;
      if (wpt_hit) cz[2] = 1;
      if ((core_rst && m_cr) || (hard_fault && m_ch)) cz[3] = 1;
      if (ext_req) cz[4] = 1;
    end
    stopn = cz != 0;
    keyed = reg_wr && reg_sel == 0 && reg_wdata[31:16] == 16'hA05F;
    @(posedge clk);
    m_halted = m_en && (stopn || (m_halted && m_stop));
    if (reg_wr && reg_sel == 1) m_why = m_why & ~reg_wdata[4:0];
    m_why = m_why | cz;
    if (reg_rd && reg_sel == 0) begin m_rs = 0; m_rt = 0; end
    if (core_rst) m_rs = 1;
    if (insn_ret) m_rt = 1;
    if (reg_wr && reg_sel == 2) begin m_cr = reg_wdata[0]; m_ch = reg_wdata[10]; m_ct = reg_wdata[24]; end
    if (keyed) begin
      m_en = reg_wdata[0]; m_stop = reg_wdata[1] || stopn; m_step = reg_wdata[2];
      m_mask = reg_wdata[3]; m_snap = reg_wdata[5];
    end else if (stopn) m_stop = 1;
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1; cyc(); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rdchk(input logic [1:0] s, input logic [31:0] exp, input string tag);
    reg_sel = s; reg_rd = 1; #1;
    check(reg_rdata, exp, tag);
    cyc(); reg_rd = 0;
  endtask

  task automatic pulse_ev(ref logic sig);
    sig = 1; cyc(); sig = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rdchk(0, 32'h0, "R2 reset value");
    rdchk(1, 32'h0, "R6 reset value");
    wr(0, 32'h0000_0003);
    rdchk(0, 32'h0, "R1 unkeyed write ignored");
    wr(0, 32'hA05E_0001);
    rdchk(0, 32'h0, "R1 wrong key ignored");
    wr(0, 32'hA05F_0021);
    rdchk(0, 32'h0000_0021, "R2 enable and snap readback");
    wr(0, 32'hA05F_0003);
    cyc();
    check(core_halt, 1, "R7 halted after request");
    rdchk(0, 32'h0003_0003, "R3 halted status bits");
    rdchk(1, 32'h1, "R6 request reason");
    wr(1, 32'h1);
    rdchk(1, 32'h0, "R6 write-one clears");
    wr(0, 32'hA05F_000D);
    check(core_halt, 1, "R7 still halted one edge after keyed release");
    cyc();
    check(core_halt, 0, "R7 released");
    check(step_go, 1, "R8 step permitted");
    check(irq_mask, 1, "R12 mask while stepping");
    repeat (2) cyc();
    pulse_ev(insn_ret);
    check(core_halt, 1, "R8 stopped after one instruction");
    check(step_go, 0, "R8 no second step");
    rdchk(0, 32'h0103_000F, "R5 retire sticky");
    rdchk(0, 32'h0003_000F, "R5 cleared by read");
    wr(1, 32'h1F);
    wr(0, 32'hA05F_0001); cyc();
    pulse_ev(bkpt_hit);
    rdchk(1, 32'h2, "R9 breakpoint reason");
    wr(0, 32'hA05F_0001); cyc();
    pulse_ev(wpt_hit);
    wr(0, 32'hA05F_0001); cyc();
    pulse_ev(ext_req);
    rdchk(1, 32'h16, "R9 watchpoint and external reasons");
    wr(2, 32'hFFFF_FFFF);
    rdchk(2, 32'h0100_0401, "R10 catch layout");
    wr(1, 32'h1F);
    wr(0, 32'hA05F_0001); cyc();
    pulse_ev(core_rst);
    rdchk(1, 32'h8, "R10 reset catch");
    rdchk(0, 32'h0203_0003, "R4 reset seen");
    rdchk(0, 32'h0003_0003, "R4 cleared by read");
    wr(1, 32'h8);
    wr(0, 32'hA05F_0001); cyc();
    pulse_ev(hard_fault);
    rdchk(1, 32'h8, "R10 hard-fault catch");
    wr(1, 32'h1F);
    wr(0, 32'hA05F_0002); cyc();
    check(core_halt, 0, "R11 no halt while disabled");
    pulse_ev(bkpt_hit);
    pulse_ev(ext_req);
    rdchk(1, 32'h0, "R11 events ignored while disabled");
    wr(0, 32'hA05F_0008);
    check(irq_mask, 0, "R12 mask needs enable");
    core_sleep = 1; core_lockup = 1;
    rdchk(0, 32'h000C_0008, "R3 sleep and lockup");
    core_sleep = 0; core_lockup = 0;
    wr(0, 32'hA05F_0001); cyc();
    pulse_ev(bkpt_hit);
    wr(0, 32'hA05F_0000); cyc();
    check(core_halt, 0, "R11 disable releases core");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule